// File: doc/BRIEF.md
# Extended-Precision Exponent and Significand Splitter

This execution unit accepts one 80-bit extended-precision operand and splits it into two floating-point results. The first result keeps the operand's sign and 64-bit significand and forces its exponent to a true value of zero. The second result is the operand's unbiased exponent, converted into a normalized floating-point number. After completion, the significand result belongs at the new top of the register stack and the exponent result in the slot directly below it. The surrounding stack logic therefore performs one push, and TOP decreases by one.

The unit also reports the stack condition bit C1 and four exception flags: stack fault, invalid operation, zero divide and denormal operand. The caller supplies a tag that says whether the source slot is empty and a tag that says whether the push slot is occupied. The caller also supplies the masks for the invalid, zero-divide and denormal exceptions. The `push_o` output tells the stack logic whether it should write the two results.

Operands arrive through a valid/ready input. Each result is held in one output register with its own valid/ready pair.

Top module: `xsplit_unit`

## Requirements
- R1: For a normal source (exponent field 0001h..7FFEh with bit 63 set), `sig_o` equals the source sign at bit 79, exponent field 3FFFh at bits 78:64, and the source bits 63:0 unchanged. No flag is raised.
- R2: For a normal source, `exp_o` encodes the integer (field − 3FFFh) as a normalized float: the sign at bit 79, field 3FFFh plus the index of the magnitude's top set bit, and the magnitude shifted left until bit 63 is set. The value zero encodes as all zeros.
- R3: For a source with exponent field 0 and a nonzero significand, the denormal flag is raised. The significand is shifted left by its leading-zero count k so that bit 63 is set, and that shifted significand is used. The exponent result is −16382 − k, so an operand with bit 63 already set gives −16382.
- R4: For a zero source, the zero-divide flag is raised. When the result is written, `sig_o` is zero carrying the source sign, and `exp_o` is minus infinity (bit 79 = 1, field 7FFFh, bits 63:0 = 8000_0000_0000_0000h).
- R5: A signaling NaN (field 7FFFh, bits 63:62 = 10, bits 61:0 nonzero) raises the invalid flag. So does an unsupported encoding (bit 63 clear with a nonzero exponent field). When written, both results are the indefinite value: bit 79 = 1, field 7FFFh, bits 63:0 = C000_0000_0000_0000h.
- R6: A quiet NaN (field 7FFFh, bits 63:62 = 11) is copied unchanged into both results, and no flag is raised.
- R7: An infinity (field 7FFFh, bits 63:0 = 8000_0000_0000_0000h) is copied unchanged into `sig_o`. `exp_o` is plus infinity, and no flag is raised.
- R8: When `src_empty_i` is 1, the stack-fault and invalid flags are raised and C1 is 0. This check takes precedence over the push-slot check and over the operand class. When written, both results are the indefinite value.
- R9: When the source slot holds a value and `dst_full_i` is 1, the stack-fault and invalid flags are raised and C1 is 1. When written, both results are the indefinite value. C1 is 0 in every other case.
- R10: `push_o` is 0 exactly when a raised flag has its mask at 0. The invalid mask covers stack faults. Otherwise `push_o` is 1.
- R11: A result appears in the cycle after its operand is accepted. It stays unchanged while `out_valid_o` is 1 and `out_ready_i` is 0. `in_ready_o` is 1 when the output register is empty or is being drained.
- R12: While `rst_ni` is low, `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operand offered |
| in_ready_o | output | 1 | Operand can be taken this cycle |
| src_i | input | 80 | Source operand |
| src_empty_i | input | 1 | Source stack slot is empty |
| dst_full_i | input | 1 | Push slot is occupied |
| mask_inv_i | input | 1 | Invalid-operation mask (also covers stack faults) |
| mask_zdiv_i | input | 1 | Zero-divide mask |
| mask_den_i | input | 1 | Denormal-operand mask |
| out_valid_o | output | 1 | Result register holds a result |
| out_ready_i | input | 1 | Consumer takes the result this cycle |
| sig_o | output | 80 | Significand result (new top of stack) |
| exp_o | output | 80 | Exponent result (slot below top) |
| push_o | output | 1 | Write both results and decrement TOP |
| flag_c1_o | output | 1 | Condition bit C1 |
| flag_sf_o | output | 1 | Stack fault |
| flag_ie_o | output | 1 | Invalid operation |
| flag_ze_o | output | 1 | Zero divide |
| flag_de_o | output | 1 | Denormal operand |

## Verification
The assertions assume that an offered operand, together with its tags and masks, stays unchanged until `in_ready_o` accepts it. They also assume that `out_ready_i` may change only between clock edges. The driver task keeps every input steady from one falling edge through the accepting rising edge, and it deasserts `in_valid_i` just after that edge. The ready driver changes `out_ready_i` at random only after a rising edge, so backpressure holds results in place without breaking that assumption. The stimulus covers normals across the full exponent range, zeros of both signs, denormals at several shift counts, infinities, both NaN kinds, unsupported encodings, and empty and full slots with the masks set and cleared.

// File: rtl/xsplit_pkg.sv
package xsplit_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_DENORM,
    CLS_NORMAL,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN,
    CLS_UNSUP
  } opnd_cls_e;

endpackage

// File: rtl/xsplit_lzc.sv
module xsplit_lzc #(
  parameter int WIDTH = 64,
  parameter int CNT_W = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  always_comb begin
    cnt_o = CNT_W'(WIDTH);
    // highest set bit is visited last and wins
    for (int i = 0; i < WIDTH; i++) begin
      if (vec_i[i]) cnt_o = CNT_W'(WIDTH - 1 - i);
    end
  end

  assign zero_o = ~|vec_i;

endmodule

// File: rtl/xsplit_classify.sv
module xsplit_classify
  import xsplit_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0]    opnd_i,
  output opnd_cls_e               cls_o,
  output logic                    sign_o,
  output logic [MAN_W-1:0]        man_o,
  output logic signed [EXP_W:0]   texp_o
);

  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int BIAS  = 2 ** (EXP_W - 1) - 1;
  localparam int CNT_W = $clog2(MAN_W) + 1;
  localparam logic [EXP_W-1:0]  EMAX   = {EXP_W{1'b1}};
  localparam logic signed [EXP_W:0] BIAS_S = (EXP_W + 1)'(BIAS);
  localparam logic signed [EXP_W:0] EMIN_S = (EXP_W + 1)'(1 - BIAS);

  logic [EXP_W-1:0] efield;
  logic [MAN_W-1:0] man;
  logic [CNT_W-1:0] lz;
  logic             man_zero;

  assign sign_o = opnd_i[W-1];
  assign efield = opnd_i[W-2 -: EXP_W];
  assign man    = opnd_i[MAN_W-1:0];

  xsplit_lzc #(.WIDTH(MAN_W), .CNT_W(CNT_W)) i_lzc (
    .vec_i  (man),
    .cnt_o  (lz),
    .zero_o (man_zero)
  );

  always_comb begin
    cls_o = CLS_NORMAL;
    if (efield == EMAX) begin
      if (!man[MAN_W-1])                cls_o = CLS_UNSUP;
      else if (man[MAN_W-2:0] == '0)    cls_o = CLS_INF;
      else if (man[MAN_W-2])            cls_o = CLS_QNAN;
      else                              cls_o = CLS_SNAN;
    end else if (efield == '0) begin
      cls_o = man_zero ? CLS_ZERO : CLS_DENORM;
    end else if (!man[MAN_W-1]) begin
      cls_o = CLS_UNSUP;
    end
  end

  always_comb begin
    if (cls_o == CLS_DENORM) begin
      man_o  = man << lz;
      texp_o = EMIN_S - $signed({{(EXP_W + 1 - CNT_W){1'b0}}, lz});
    end else begin
      man_o  = man;
      texp_o = $signed({1'b0, efield}) - BIAS_S;
    end
  end

endmodule

// File: rtl/xsplit_i2f.sv
module xsplit_i2f #(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic signed [EXP_W:0]   val_i,
  output logic [EXP_W+MAN_W:0]    fp_o
);

  localparam int BIAS  = 2 ** (EXP_W - 1) - 1;
  localparam int CNT_W = $clog2(MAN_W) + 1;

  logic [EXP_W:0]     mag;
  logic [MAN_W-1:0]   aligned;
  logic [MAN_W-1:0]   norm;
  logic [CNT_W-1:0]   lz;
  logic               is_zero;
  logic [EXP_W-1:0]   biased;

  assign mag     = val_i[EXP_W] ? (~val_i + 1'b1) : val_i;
  assign aligned = {mag, {(MAN_W - EXP_W - 1){1'b0}}};

  xsplit_lzc #(.WIDTH(MAN_W), .CNT_W(CNT_W)) i_lzc (
    .vec_i  (aligned),
    .cnt_o  (lz),
    .zero_o (is_zero)
  );

  // top set bit of mag sits at index EXP_W - lz
  assign norm   = aligned << lz;
  assign biased = EXP_W'(BIAS) + EXP_W'(EXP_W) - EXP_W'(lz);
  assign fp_o   = is_zero ? '0 : {val_i[EXP_W], biased, norm};

endmodule

// File: rtl/xsplit_unit.sv
module xsplit_unit
  import xsplit_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [EXP_W+MAN_W:0]     src_i,
  input  logic                     src_empty_i,
  input  logic                     dst_full_i,
  input  logic                     mask_inv_i,
  input  logic                     mask_zdiv_i,
  input  logic                     mask_den_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [EXP_W+MAN_W:0]     sig_o,
  output logic [EXP_W+MAN_W:0]     exp_o,
  output logic                     push_o,
  output logic                     flag_c1_o,
  output logic                     flag_sf_o,
  output logic                     flag_ie_o,
  output logic                     flag_ze_o,
  output logic                     flag_de_o
);

  localparam int W    = 1 + EXP_W + MAN_W;
  localparam int BIAS = 2 ** (EXP_W - 1) - 1;
  localparam logic [EXP_W-1:0] EMAX = {EXP_W{1'b1}};
  localparam logic [W-1:0] INDEF   = {1'b1, EMAX, 2'b11, {(MAN_W - 2){1'b0}}};
  localparam logic [W-1:0] NEG_INF = {1'b1, EMAX, 1'b1, {(MAN_W - 1){1'b0}}};
  localparam logic [W-1:0] POS_INF = {1'b0, EMAX, 1'b1, {(MAN_W - 1){1'b0}}};

  opnd_cls_e             cls;
  logic                  sign;
  logic [MAN_W-1:0]      man;
  logic signed [EXP_W:0] texp;
  logic [W-1:0]          exp_fp;

  logic [W-1:0] sig_n, exp_n;
  logic         c1_n, sf_n, ie_n, ze_n, de_n, push_n;
  logic         accept;

  xsplit_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_classify (
    .opnd_i (src_i),
    .cls_o  (cls),
    .sign_o (sign),
    .man_o  (man),
    .texp_o (texp)
  );

  xsplit_i2f #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_i2f (
    .val_i (texp),
    .fp_o  (exp_fp)
  );

  always_comb begin
    sig_n = {sign, EXP_W'(BIAS), man};
    exp_n = exp_fp;
    c1_n  = 1'b0;
    sf_n  = 1'b0;
    ie_n  = 1'b0;
    ze_n  = 1'b0;
    de_n  = 1'b0;
    if (src_empty_i) begin
      sf_n  = 1'b1;
      ie_n  = 1'b1;
      sig_n = INDEF;
      exp_n = INDEF;
    end else if (dst_full_i) begin
      sf_n  = 1'b1;
      ie_n  = 1'b1;
      c1_n  = 1'b1;
      sig_n = INDEF;
      exp_n = INDEF;
    end else begin
      unique case (cls)
        CLS_ZERO: begin
          ze_n  = 1'b1;
          sig_n = {sign, {(W - 1){1'b0}}};
          exp_n = NEG_INF;
        end
        CLS_DENORM: de_n = 1'b1;
        CLS_INF: begin
          sig_n = src_i;
          exp_n = POS_INF;
        end
        CLS_QNAN: begin
          sig_n = src_i;
          exp_n = src_i;
        end
        CLS_SNAN, CLS_UNSUP: begin
          ie_n  = 1'b1;
          sig_n = INDEF;
          exp_n = INDEF;
        end
        default: ;
      endcase
    end
    push_n = ~((ie_n & ~mask_inv_i) | (ze_n & ~mask_zdiv_i) | (de_n & ~mask_den_i));
  end

  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      sig_o       <= '0;
      exp_o       <= '0;
      push_o      <= 1'b0;
      flag_c1_o   <= 1'b0;
      flag_sf_o   <= 1'b0;
      flag_ie_o   <= 1'b0;
      flag_ze_o   <= 1'b0;
      flag_de_o   <= 1'b0;
    end else if (accept) begin
      out_valid_o <= 1'b1;
      sig_o       <= sig_n;
      exp_o       <= exp_n;
      push_o      <= push_n;
      flag_c1_o   <= c1_n;
      flag_sf_o   <= sf_n;
      flag_ie_o   <= ie_n;
      flag_ze_o   <= ze_n;
      flag_de_o   <= de_n;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(sig_o) && $stable(exp_o) && $stable(push_o)); // R11

  AST_SIG_UNIT_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && push_o && !flag_ie_o && !flag_ze_o && sig_o[W-2 -: EXP_W] != EMAX
    |-> sig_o[W-2 -: EXP_W] == EXP_W'(BIAS) && sig_o[MAN_W-1]); // R1

  AST_EXP_NORMALIZED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && push_o && exp_o[W-2 -: EXP_W] != '0 |-> exp_o[MAN_W-1]); // R2

  AST_ZERO_RESULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && push_o && flag_ze_o |-> exp_o == NEG_INF && sig_o[W-2:0] == '0); // R4

  AST_SINGLE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $countones({flag_ie_o, flag_ze_o, flag_de_o}) <= 1); // R5

  AST_SF_WITH_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && flag_sf_o |-> flag_ie_o); // R8

  AST_C1_ONLY_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && flag_c1_o |-> flag_sf_o); // R9

endmodule

// File: tb/test_xsplit_unit.sv
module test_xsplit_unit;

  localparam logic [79:0] INDEF   = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};
  localparam logic [79:0] NEG_INF = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
  localparam logic [79:0] POS_INF = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic in_ready_o;
  logic [79:0] src_i = '0;
  logic src_empty_i = 1'b0, dst_full_i = 1'b0;
  logic mask_inv_i = 1'b1, mask_zdiv_i = 1'b1, mask_den_i = 1'b1;
  logic out_valid_o;
  logic out_ready_i = 1'b1;
  logic [79:0] sig_o, exp_o;
  logic push_o, flag_c1_o, flag_sf_o, flag_ie_o, flag_ze_o, flag_de_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [79:0] sig;
    logic [79:0] ex;
    logic        push, c1, sf, ie, ze, de;
    string       req;
  } item_t;

  item_t q[$];

  always #4 clk_i = ~clk_i;

  xsplit_unit i_xsplit_unit (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .src_i, .src_empty_i, .dst_full_i,
    .mask_inv_i, .mask_zdiv_i, .mask_den_i, .out_valid_o, .out_ready_i,
    .sig_o, .exp_o, .push_o, .flag_c1_o, .flag_sf_o, .flag_ie_o, .flag_ze_o, .flag_de_o
  );

  task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: act %h exp %h", req, what, act, expv);
    end
  endtask

  function automatic logic [79:0] int_to_fp(input int v);
    int unsigned m;
    int p;
    logic [63:0] sm;
    if (v == 0) return '0;
    m = (v < 0) ? int'(-v) : v;
    p = 0;
    while ((m >> (p + 1)) != 0) p++;
    sm = 64'(m) << (63 - p);
    return {v < 0, 15'(16383 + p), sm};
  endfunction

  function automatic item_t model(input logic [79:0] x, input logic emp, input logic full,
                                  input logic mi, input logic mz, input logic md, input string req);
    item_t r;
    logic [14:0] e;
    logic [63:0] m;
    int k;
    e = x[78:64];
    m = x[63:0];
    r.sig = '0; r.ex = '0;
    r.c1 = 0; r.sf = 0; r.ie = 0; r.ze = 0; r.de = 0;
    r.req = req;
    if (emp) begin
      r.sf = 1; r.ie = 1; r.sig = INDEF; r.ex = INDEF;
    end else if (full) begin
      r.sf = 1; r.ie = 1; r.c1 = 1; r.sig = INDEF; r.ex = INDEF;
    end else if (e == 15'h7FFF) begin
      if (!m[63] || (m[62:0] != 0 && !m[62])) begin
        r.ie = 1; r.sig = INDEF; r.ex = INDEF;
      end else if (m[62:0] == 0) begin
        r.sig = x; r.ex = POS_INF;
      end else begin
        r.sig = x; r.ex = x;
      end
    end else if (e == 0) begin
      if (m == 0) begin
        r.ze = 1; r.sig = {x[79], 79'd0}; r.ex = NEG_INF;
      end else begin
        r.de = 1;
        k = 0;
        while (!m[63]) begin m = m << 1; k++; end
        r.sig = {x[79], 15'h3FFF, m};
        r.ex = int_to_fp(-16382 - k);
      end
    end else if (!m[63]) begin
      r.ie = 1; r.sig = INDEF; r.ex = INDEF;
    end else begin
      r.sig = {x[79], 15'h3FFF, m};
      r.ex = int_to_fp(int'(e) - 16383);
    end
    r.push = !((r.ie && !mi) || (r.ze && !mz) || (r.de && !md));
    return r;
  endfunction

  task automatic send(input logic [79:0] x, input logic emp, input logic full,
                      input logic mi, input logic mz, input logic md, input string req);
    @(negedge clk_i);
    in_valid_i = 1'b1; src_i = x; src_empty_i = emp; dst_full_i = full;
    mask_inv_i = mi; mask_zdiv_i = mz; mask_den_i = md;
    while (!in_ready_o) @(negedge clk_i);
    q.push_back(model(x, emp, full, mi, mz, md, req));
    @(posedge clk_i);
    #1 in_valid_i = 1'b0;
  endtask

  // backpressure, changed only just after a rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1 out_ready_i = ($urandom % 4) != 0;
    end
  end

  // monitor / scoreboard
  initial begin
    logic hold_pend;
    logic [79:0] hold_sig, hold_exp;
    item_t it;
    hold_pend = 0; hold_sig = '0; hold_exp = '0;
    wait (rst_ni);
    forever begin
      @(negedge clk_i);
      if (hold_pend) begin
        chk("R11", "held valid", {79'd0, out_valid_o}, 80'd1);
        chk("R11", "held sig", sig_o, hold_sig);
        chk("R11", "held exp", exp_o, hold_exp);
        hold_pend = 0;
      end
      if (out_valid_o && out_ready_i) begin
        if (q.size() == 0) begin
          chk("R11", "unexpected result", {79'd0, out_valid_o}, 80'd0);
        end else begin
          it = q.pop_front();
          chk(it.req, "flags", {74'd0, push_o, flag_c1_o, flag_sf_o, flag_ie_o, flag_ze_o, flag_de_o},
              {74'd0, it.push, it.c1, it.sf, it.ie, it.ze, it.de});
          if (it.push) begin
            chk(it.req, "sig", sig_o, it.sig);
            chk(it.req, "exp", exp_o, it.ex);
          end
        end
      end else if (out_valid_o) begin
        hold_pend = 1; hold_sig = sig_o; hold_exp = exp_o;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R11 watchdog: act hung exp done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R12", "valid in reset", {79'd0, out_valid_o}, 80'd0);
    chk("R12", "ready in reset", {79'd0, in_ready_o}, 80'd1);
    rst_ni = 1'b1;

    // R1 R2 normals
    send({1'b0, 15'h3FFF, 64'h8000_0000_0000_0000}, 0, 0, 1, 1, 1, "R2");
    send({1'b1, 15'h4005, 64'hC123_4567_89AB_CDEF}, 0, 0, 1, 1, 1, "R1");
    send({1'b0, 15'h3FFE, 64'hFFFF_FFFF_FFFF_FFFF}, 0, 0, 1, 1, 1, "R2");
    send({1'b1, 15'h7FFE, 64'h8000_0000_0000_0001}, 0, 0, 1, 1, 1, "R2");
    send({1'b0, 15'h0001, 64'hA5A5_A5A5_A5A5_A5A5}, 0, 0, 0, 0, 0, "R1");
    // R3 denormals
    send({1'b0, 15'h0000, 64'h0000_0000_0000_0001}, 0, 0, 1, 1, 1, "R3");
    send({1'b1, 15'h0000, 64'h4000_0000_0000_0000}, 0, 0, 1, 1, 1, "R3");
    send({1'b0, 15'h0000, 64'h8000_0000_0000_0003}, 0, 0, 1, 1, 1, "R3");
    send({1'b0, 15'h0000, 64'h0000_1234_0000_0000}, 0, 0, 1, 1, 0, "R10");
    // R4 zeros
    send({1'b0, 79'd0}, 0, 0, 1, 1, 1, "R4");
    send({1'b1, 79'd0}, 0, 0, 1, 1, 1, "R4");
    send({1'b1, 79'd0}, 0, 0, 1, 0, 1, "R10");
    // R5 invalid
    send({1'b0, 15'h7FFF, 64'h8000_0000_0000_0001}, 0, 0, 1, 1, 1, "R5");
    send({1'b1, 15'h4000, 64'h4000_0000_0000_0000}, 0, 0, 1, 1, 1, "R5");
    send({1'b0, 15'h7FFF, 64'h0000_0000_0000_0000}, 0, 0, 1, 1, 1, "R5");
    send({1'b0, 15'h7FFF, 64'hA000_0000_0000_0000}, 0, 0, 0, 1, 1, "R10");
    // R6 quiet NaN, R7 infinities
    send({1'b1, 15'h7FFF, 64'hC000_0000_0000_0042}, 0, 0, 1, 1, 1, "R6");
    send({1'b0, 15'h7FFF, 64'hE000_0000_0000_0000}, 0, 0, 0, 0, 0, "R6");
    send(POS_INF, 0, 0, 1, 1, 1, "R7");
    send(NEG_INF, 0, 0, 0, 0, 0, "R7");
    // R8 R9 stack faults
    send({1'b0, 15'h3FFF, 64'h8000_0000_0000_0000}, 1, 0, 1, 1, 1, "R8");
    send({1'b0, 79'd0}, 1, 1, 1, 1, 1, "R8");
    send({1'b0, 15'h3FFF, 64'h8000_0000_0000_0000}, 1, 0, 0, 1, 1, "R8");
    send({1'b0, 15'h4001, 64'h9000_0000_0000_0000}, 0, 1, 1, 1, 1, "R9");
    send({1'b0, 15'h0000, 64'h0000_0000_0000_0010}, 0, 1, 0, 1, 1, "R9");

    // mixed random traffic
    for (int i = 0; i < 300; i++) begin
      logic [79:0] x;
      int sel;
      sel = $urandom % 8;
      x = {$urandom, $urandom, $urandom};
      case (sel)
        0: x[78:64] = 15'h0000;
        1: begin x[78:64] = 15'h0000; x[63:0] = 64'd1 << ($urandom % 64); end
        2: x[78:64] = 15'h7FFF;
        3: x[78:0] = '0;
        default: x[63] = 1'b1;
      endcase
      if (x[78:64] == 15'h0000 && sel == 0) x[63] = 1'b0;
      send(x, ($urandom % 16) == 0, ($urandom % 16) == 0,
           $urandom % 2, $urandom % 2, $urandom % 2, "R2");
    end

    while (q.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule